// File: doc/BRIEF.md
# Byte Peripheral Bus Bridge

This block sits between a 16-bit CPU memory bus and eight peripheral module slots. It watches each CPU access. When the address falls inside the peripheral window, it decodes the slot-select bits into one module-enable line. It also hands the five low address bits to that slot only. Every unselected slot sees its enable low and its address held at zero, so it stays idle and keeps its register contents. Slot 0 is reserved for the special function registers.

Each slot is either byte-wide or word-wide, chosen by a parameter mask. Slot 0 is always byte-wide. Word slots are passed straight through in both directions. Byte slots accept byte accesses only. For a byte slot, write data is taken from the byte lane chosen by address bit 0, and read data is returned on that same lane with the other lane zeroed. A word access to a byte slot is not performed: no enable is raised, the read data is zero, and a sticky error flag is set. The flag is read and cleared through a dedicated bridge address. The interrupt request inputs of all slots are merged into one request output.

Top module: `pbus_bridge`

## Requirements
- R1: An access (`cpu_en`=1) whose address bits [15:8] equal 0x00 raises exactly one `mod_en` bit in the same cycle, namely the slot given by address bits [7:5]. No other enable is ever high, and no enable is high outside the window.
- R2: The selected slot's 5-bit field of `per_addr` (slot i at bits [5i+4:5i]) equals `cpu_addr[4:0]`. The fields of all unselected slots are zero.
- R3: A byte read (`cpu_byte`=1) from a byte slot returns the slot's `per_rdata` bits [7:0] on `cpu_rdata[7:0]` when `cpu_addr[0]`=0, or on `cpu_rdata[15:8]` when it is 1. The other lane is zero.
- R4: A byte write to a byte slot drives `per_wdata` = {8'h00, byte}, where byte is `cpu_wdata[7:0]` for an even address and `cpu_wdata[15:8]` for an odd address.
- R5: Any access to a word slot (mask bit set, slot not 0) passes `per_wdata` = `cpu_wdata` and `cpu_rdata` = the slot's `per_rdata` unchanged, and drives `per_byte` = `cpu_byte`.
- R6: A word access (`cpu_byte`=0) to a byte slot raises no enable and returns `cpu_rdata`=0. `bus_err` is high from the next clock edge and stays high through later accesses to other addresses.
- R7: A write to address 0x0100 clears `bus_err` at the next edge. A read of 0x0100 returns {15'b0, bus_err}.
- R8: Slot 0 is byte-wide whatever the width mask says.
- R9: `irq_out` is high exactly when at least one `irq_in` bit is high.
- R10: After reset `bus_err` is 0. With `cpu_en`=0 all enables are low, `per_we` is 0 and `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_en | input | 1 | Access strobe for the current cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Read data returned to the CPU |
| mod_en | output | 8 | Per-slot module enable |
| per_addr | output | 40 | Per-slot 5-bit address, slot i at [5i+4:5i] |
| per_we | output | 1 | Write strobe to the selected slot |
| per_byte | output | 1 | Byte-access indication to word slots |
| per_wdata | output | 16 | Write data to the selected slot |
| per_rdata | input | 128 | Per-slot read data, slot i at [16i+15:16i] |
| irq_in | input | 8 | Per-slot interrupt requests |
| irq_out | output | 1 | Merged interrupt request |
| bus_err | output | 1 | Sticky word-to-byte-slot violation flag |

## Verification
The assertions assume that `cpu_en`, `cpu_we`, `cpu_byte` and `cpu_addr` are stable through each cycle and driven to known values from reset onward. They also assume the error-register address lies outside the slot window, so that setting and clearing the flag can never be requested in the same cycle. The bench changes inputs only half a cycle away from the rising edge and holds each access for one full cycle. It places the error register at 0x0100, above the 0x0000–0x00FF window, so every stimulus stays within these assumptions.

// File: rtl/pbus_pkg.sv
// Package: shared types for the byte peripheral bus bridge.
// Assumes: one access is classified per cycle; the classes are exclusive.
package pbus_pkg;

    // Classification of the current CPU access
    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,  // no access, or address outside all regions
        ACC_BYTE   = 3'd1,  // byte access to a byte-wide slot
        ACC_WORD   = 3'd2,  // any access to a word-wide slot
        ACC_BAD    = 3'd3,  // word access to a byte-wide slot (refused)
        ACC_ERRREG = 3'd4   // access to the bridge error register
    } acc_kind_t;

endpackage

// File: rtl/pbus_decode.sv
// Module: pbus_decode
// Classifies each CPU access and picks the slot index from the address.
// Assumes: the slot window is aligned to NUM_SLOTS * 2**SLOT_AW bytes, and
// the error register address lies outside it. Slot 0 is forced byte-wide.
module pbus_decode
    import pbus_pkg::*;
#(
    parameter int                NUM_SLOTS      = 8,
    parameter int                SLOT_AW        = 5,
    parameter int                CPU_AW         = 16,
    parameter logic [CPU_AW-1:0] WIN_BASE       = 16'h0000,
    parameter logic [CPU_AW-1:0] ERR_ADDR       = 16'h0100,
    parameter logic [NUM_SLOTS-1:0] SLOT_WORD_MASK = 8'hF0,
    localparam int               SEL_W          = $clog2(NUM_SLOTS),
    localparam int               WIN_LSB        = SLOT_AW + SEL_W
) (
    input  logic              cpu_en,
    input  logic              cpu_byte,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [SEL_W-1:0]  sel_idx,
    output acc_kind_t         acc_kind
);

    logic in_win;
    logic slot_word;

    // Window hit and slot width lookup
    always_comb begin
        in_win    = (cpu_addr[CPU_AW-1:WIN_LSB] == WIN_BASE[CPU_AW-1:WIN_LSB]);
        sel_idx   = cpu_addr[WIN_LSB-1:SLOT_AW];
        slot_word = SLOT_WORD_MASK[sel_idx] && (sel_idx != '0);
    end

    // Access classification
    always_comb begin
        acc_kind = ACC_NONE;
        if (cpu_en) begin
            if (cpu_addr == ERR_ADDR)
                acc_kind = ACC_ERRREG;
            else if (in_win) begin
                if (slot_word)
                    acc_kind = ACC_WORD;
                else if (cpu_byte)
                    acc_kind = ACC_BYTE;
                else
                    acc_kind = ACC_BAD;
            end
        end
    end

endmodule

// File: rtl/pbus_rdmux.sv
// Module: pbus_rdmux
// Selects the addressed slot's read data and steers byte data onto a lane.
// Assumes: byte slots present their register on bits [7:0] of their bus.
module pbus_rdmux
    import pbus_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int DW        = 16,
    localparam int SEL_W    = $clog2(NUM_SLOTS),
    localparam int BW       = DW / 2
) (
    input  acc_kind_t              acc_kind,
    input  logic [SEL_W-1:0]       sel_idx,
    input  logic                   lane_hi,
    input  logic                   err_flag,
    input  logic [NUM_SLOTS*DW-1:0] per_rdata,
    output logic [DW-1:0]          cpu_rdata
);

    logic [DW-1:0] slot_word;

    // Pick the addressed slot's data bus
    always_comb slot_word = per_rdata[sel_idx*DW +: DW];

    // Form the CPU read data per access class
    always_comb begin
        cpu_rdata = '0;
        unique case (acc_kind)
            ACC_WORD:   cpu_rdata = slot_word;
            ACC_BYTE:   cpu_rdata = lane_hi ? {slot_word[BW-1:0], {BW{1'b0}}}
                                            : {{BW{1'b0}}, slot_word[BW-1:0]};
            ACC_ERRREG: cpu_rdata = {{(DW-1){1'b0}}, err_flag};
            default:    cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pbus_errflag.sv
// Module: pbus_errflag
// Sticky flag recording a refused word access to a byte slot.
// Assumes: set and clear requests never coincide (distinct addresses).
module pbus_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);

    // Set on violation, clear on write to the error register
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end

endmodule

// File: rtl/pbus_bridge.sv
// Module: pbus_bridge (top)
// Bridges a 16-bit CPU bus to byte- and word-wide peripheral slots with
// per-slot enables, gated 5-bit addresses, lane conversion, a sticky
// width-violation flag and a merged interrupt request.
// Assumes: CPU inputs are stable for the whole cycle; reads are combinational.
module pbus_bridge
    import pbus_pkg::*;
#(
    parameter int                   NUM_SLOTS      = 8,
    parameter int                   SLOT_AW        = 5,
    parameter int                   CPU_AW         = 16,
    parameter int                   DW             = 16,
    parameter logic [CPU_AW-1:0]    WIN_BASE       = 16'h0000,
    parameter logic [CPU_AW-1:0]    ERR_ADDR       = 16'h0100,
    parameter logic [NUM_SLOTS-1:0] SLOT_WORD_MASK = 8'hF0,
    localparam int                  SEL_W          = $clog2(NUM_SLOTS),
    localparam int                  BW             = DW / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_en,
    input  logic                       cpu_we,
    input  logic                       cpu_byte,
    input  logic [CPU_AW-1:0]          cpu_addr,
    input  logic [DW-1:0]              cpu_wdata,
    output logic [DW-1:0]              cpu_rdata,
    output logic [NUM_SLOTS-1:0]       mod_en,
    output logic [NUM_SLOTS*SLOT_AW-1:0] per_addr,
    output logic                       per_we,
    output logic                       per_byte,
    output logic [DW-1:0]              per_wdata,
    input  logic [NUM_SLOTS*DW-1:0]    per_rdata,
    input  logic [NUM_SLOTS-1:0]       irq_in,
    output logic                       irq_out,
    output logic                       bus_err
);

    logic [SEL_W-1:0] sel_idx;
    acc_kind_t        acc_kind;
    logic             slot_go;

    pbus_decode #(
        .NUM_SLOTS      (NUM_SLOTS),
        .SLOT_AW        (SLOT_AW),
        .CPU_AW         (CPU_AW),
        .WIN_BASE       (WIN_BASE),
        .ERR_ADDR       (ERR_ADDR),
        .SLOT_WORD_MASK (SLOT_WORD_MASK)
    ) i_decode (
        .cpu_en   (cpu_en),
        .cpu_byte (cpu_byte),
        .cpu_addr (cpu_addr),
        .sel_idx  (sel_idx),
        .acc_kind (acc_kind)
    );

    // An access that actually reaches a slot
    always_comb slot_go = (acc_kind == ACC_BYTE) || (acc_kind == ACC_WORD);

    // Per-slot enable and gated address
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb begin
            mod_en[g] = slot_go && (sel_idx == SEL_W'(g));
            per_addr[g*SLOT_AW +: SLOT_AW] =
                mod_en[g] ? cpu_addr[SLOT_AW-1:0] : '0;
        end
    end

    // Write strobe, width indication and write-lane conversion
    always_comb begin
        per_we    = cpu_we && slot_go;
        per_byte  = slot_go && cpu_byte;
        per_wdata = '0;
        if (acc_kind == ACC_WORD)
            per_wdata = cpu_wdata;
        else if (acc_kind == ACC_BYTE)
            per_wdata = {{BW{1'b0}}, cpu_addr[0] ? cpu_wdata[DW-1:BW]
                                                 : cpu_wdata[BW-1:0]};
    end

    pbus_rdmux #(
        .NUM_SLOTS (NUM_SLOTS),
        .DW        (DW)
    ) i_rdmux (
        .acc_kind  (acc_kind),
        .sel_idx   (sel_idx),
        .lane_hi   (cpu_addr[0]),
        .err_flag  (bus_err),
        .per_rdata (per_rdata),
        .cpu_rdata (cpu_rdata)
    );

    pbus_errflag i_errflag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (acc_kind == ACC_BAD),
        .clr_req ((acc_kind == ACC_ERRREG) && cpu_we),
        .flag    (bus_err)
    );

    // Merge slot interrupt requests
    always_comb irq_out = |irq_in;

endmodule

// File: rtl/pbus_bridge_chk.sv
// Module: pbus_bridge_chk
// Port-level temporal checks for pbus_bridge, attached by bind.
// Assumes: same parameters as the bridge; error register outside the window.
module pbus_bridge_chk #(
    parameter int                   NUM_SLOTS      = 8,
    parameter int                   SLOT_AW        = 5,
    parameter int                   CPU_AW         = 16,
    parameter logic [CPU_AW-1:0]    WIN_BASE       = 16'h0000,
    parameter logic [CPU_AW-1:0]    ERR_ADDR       = 16'h0100,
    parameter logic [NUM_SLOTS-1:0] SLOT_WORD_MASK = 8'hF0,
    localparam int                  SEL_W          = $clog2(NUM_SLOTS),
    localparam int                  WIN_LSB        = SLOT_AW + SEL_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cpu_en,
    input logic                         cpu_we,
    input logic                         cpu_byte,
    input logic [CPU_AW-1:0]            cpu_addr,
    input logic [NUM_SLOTS-1:0]         mod_en,
    input logic [NUM_SLOTS*SLOT_AW-1:0] per_addr,
    input logic                         bus_err
);

    logic [SEL_W-1:0] idx;
    logic             win, byte_slot, bad_acc, clr_acc;

    // Independent view of the access class from ports
    always_comb begin
        idx       = cpu_addr[WIN_LSB-1:SLOT_AW];
        win       = cpu_addr[CPU_AW-1:WIN_LSB] == WIN_BASE[CPU_AW-1:WIN_LSB];
        byte_slot = (idx == '0) || !SLOT_WORD_MASK[idx];
        bad_acc   = cpu_en && win && byte_slot && !cpu_byte;
        clr_acc   = cpu_en && cpu_we && (cpu_addr == ERR_ADDR);
    end

    assert_en_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_en));

    assert_idle_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en == '0) |-> (per_addr == '0));

    assert_bad_no_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |-> (mod_en == '0));

    assert_bad_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |=> bus_err);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !clr_acc) |=> bus_err);

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_acc |=> !bus_err);

    assert_idle_no_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_en |-> (mod_en == '0));

endmodule

bind pbus_bridge pbus_bridge_chk #(
    .NUM_SLOTS      (NUM_SLOTS),
    .SLOT_AW        (SLOT_AW),
    .CPU_AW         (CPU_AW),
    .WIN_BASE       (WIN_BASE),
    .ERR_ADDR       (ERR_ADDR),
    .SLOT_WORD_MASK (SLOT_WORD_MASK)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_en   (cpu_en),
    .cpu_we   (cpu_we),
    .cpu_byte (cpu_byte),
    .cpu_addr (cpu_addr),
    .mod_en   (mod_en),
    .per_addr (per_addr),
    .bus_err  (bus_err)
);

// File: tb/test_pbus_bridge.sv
// Directed bench for pbus_bridge: one task per scenario, each self-checking.
module test_pbus_bridge;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_en = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
    logic [15:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [15:0]  cpu_rdata;
    logic [7:0]   mod_en;
    logic [39:0]  per_addr;
    logic         per_we, per_byte;
    logic [15:0]  per_wdata;
    logic [127:0] per_rdata;
    logic [7:0]   irq_in = '0;
    logic         irq_out, bus_err;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;  // 250 MHz

    pbus_bridge i_pbus_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_we(cpu_we),
        .cpu_byte(cpu_byte), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .mod_en(mod_en), .per_addr(per_addr),
        .per_we(per_we), .per_byte(per_byte), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .irq_in(irq_in), .irq_out(irq_out),
        .bus_err(bus_err)
    );

    // Slot i returns {8'hA0+i, 8'h50+i}
    always_comb
        for (int i = 0; i < 8; i++)
            per_rdata[i*16 +: 16] = {8'hA0 + 8'(i), 8'h50 + 8'(i)};

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply an access at the falling edge and let logic settle
    task automatic drive(logic en, logic we, logic byt, logic [15:0] a,
                         logic [15:0] wd);
        @(negedge clk);
        cpu_en = en; cpu_we = we; cpu_byte = byt; cpu_addr = a; cpu_wdata = wd;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000);
    endtask

    task automatic t_reset();
        idle();
        chk("R10 err after reset", 64'(bus_err), 64'd0);
        chk("R10 idle enables", 64'(mod_en), 64'd0);
        chk("R10 idle we", 64'(per_we), 64'd0);
        chk("R10 idle rdata", 64'(cpu_rdata), 64'd0);
    endtask

    task automatic t_select();
        for (int s = 0; s < 8; s++) begin
            drive(1'b1, 1'b0, 1'b1, 16'(s*32 + 5'h13), 16'h0000);
            chk("R1 select", 64'(mod_en), 64'(8'b1 << s));
            chk("R2 slot addr", 64'(per_addr), 64'(40'h13 << (5*s)));
        end
        drive(1'b1, 1'b0, 1'b1, 16'h0213, 16'h0000);
        chk("R1 outside window", 64'(mod_en), 64'd0);
        chk("R2 outside window", 64'(per_addr), 64'd0);
    endtask

    task automatic t_byte_read();
        drive(1'b1, 1'b0, 1'b1, 16'h0042, 16'h0000);  // slot 2 even
        chk("R3 byte read low lane", 64'(cpu_rdata), 64'h0052);
        drive(1'b1, 1'b0, 1'b1, 16'h0063, 16'h0000);  // slot 3 odd
        chk("R3 byte read high lane", 64'(cpu_rdata), 64'h5300);
    endtask

    task automatic t_byte_write();
        drive(1'b1, 1'b1, 1'b1, 16'h0024, 16'hBEEF);  // slot 1 even
        chk("R4 byte write even", 64'(per_wdata), 64'h00EF);
        chk("R4 byte write we", 64'(per_we), 64'd1);
        drive(1'b1, 1'b1, 1'b1, 16'h0025, 16'hBEEF);  // slot 1 odd
        chk("R4 byte write odd", 64'(per_wdata), 64'h00BE);
    endtask

    task automatic t_word_slot();
        drive(1'b1, 1'b0, 1'b0, 16'h00A4, 16'h0000);  // slot 5 word read
        chk("R5 word read", 64'(cpu_rdata), 64'hA555);
        chk("R5 word enable", 64'(mod_en), 64'h20);
        drive(1'b1, 1'b1, 1'b1, 16'h00E1, 16'h1234);  // slot 7 byte write
        chk("R5 word slot wdata", 64'(per_wdata), 64'h1234);
        chk("R5 per_byte", 64'(per_byte), 64'd1);
        drive(1'b1, 1'b0, 1'b1, 16'h0081, 16'h0000);  // slot 4 byte read
        chk("R5 word slot byte read", 64'(cpu_rdata), 64'hA454);
        chk("R6 no err from word slots", 64'(bus_err), 64'd0);
    endtask

    task automatic t_violation();
        drive(1'b1, 1'b0, 1'b0, 16'h0060, 16'h0000);  // word to slot 3
        chk("R6 no enable", 64'(mod_en), 64'd0);
        chk("R6 rdata zero", 64'(cpu_rdata), 64'd0);
        chk("R6 err not yet", 64'(bus_err), 64'd0);
        drive(1'b1, 1'b0, 1'b0, 16'h00A0, 16'h0000);
        chk("R6 err set", 64'(bus_err), 64'd1);
        idle(); idle();
        chk("R6 err sticky", 64'(bus_err), 64'd1);
        drive(1'b1, 1'b0, 1'b0, 16'h0100, 16'h0000);
        chk("R7 err readback", 64'(cpu_rdata), 64'd1);
        drive(1'b1, 1'b1, 1'b0, 16'h0100, 16'h0000);
        idle();
        chk("R7 err cleared", 64'(bus_err), 64'd0);
        drive(1'b1, 1'b0, 1'b0, 16'h0100, 16'h0000);
        chk("R7 err readback zero", 64'(cpu_rdata), 64'd0);
    endtask

    task automatic t_sfr_slot();
        drive(1'b1, 1'b0, 1'b0, 16'h0002, 16'h0000);  // word to slot 0
        chk("R8 slot0 word refused", 64'(mod_en), 64'd0);
        idle();
        chk("R8 slot0 sets err", 64'(bus_err), 64'd1);
        drive(1'b1, 1'b1, 1'b0, 16'h0100, 16'h0000);
        idle();
    endtask

    task automatic t_irq();
        irq_in = 8'h00; #1;
        chk("R9 irq none", 64'(irq_out), 64'd0);
        for (int i = 0; i < 8; i++) begin
            irq_in = 8'(1 << i); #1;
            chk("R9 irq single", 64'(irq_out), 64'd1);
        end
        irq_in = 8'h00;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_select();
        t_byte_read();
        t_byte_write();
        t_word_slot();
        t_violation();
        t_sfr_slot();
        t_irq();
        idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #40000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule